// File: doc/BRIEF.md
# Directed-Mode Mantissa Rounding Unit

This combinational unit finishes the fraction of a floating-point result. Its input is an aligned mantissa whose two lowest bits are the guard bit (bit 1) and the round bit (bit 0), together with a separate sticky bit. Those two low bits always leave the result. The remaining mantissa is either kept as it is or incremented by one at its least significant bit. Which of the two happens depends on the selected rounding direction, on the operand sign and on the discarded bits. The unit also reports whether the result was inexact and whether it was incremented.

The same mode decode settles how an overflowing result of the given sign is to be delivered. It either becomes an infinity, which raises the overflow flag, or it is clamped to the largest finite magnitude. Exponent arithmetic, renormalisation after a carry out of the top bit, and exception trapping all belong to the consumer.

Top module: `rnd_unit`

## Requirements
- R1: When no increment is applied, `mant_o` equals `mant_i` shifted right by two, and its top (carry) bit is 0.
- R2: When guard (`mant_i[1]`), round (`mant_i[0]`) and `sticky_i` are all 0, `round_up_o`, `frac_rounded_o`, `inexact_o` and `frac_inexact_o` are all 0.
- R3: `inexact_o` and `frac_inexact_o` are both 1 exactly when at least one of guard, round and sticky is 1.
- R4: In nearest mode (`mode_i` = 2'b00) an increment happens only when guard is 1 and at least one of these is 1: round, sticky, or bit 2 of `mant_i`. An exact tie therefore resolves to an even result.
- R5: In toward-zero mode (`mode_i` = 2'b01) no increment ever happens.
- R6: In toward-plus-infinity mode (`mode_i` = 2'b10) an inexact result is incremented only when `sign_i` is 0 (positive).
- R7: In toward-minus-infinity mode (`mode_i` = 2'b11) an inexact result is incremented only when `sign_i` is 1 (negative).
- R8: On an increment, `round_up_o` and `frac_rounded_o` are 1, and `mant_o` equals (`mant_i` >> 2) + 1 with full carry propagation. An all-ones kept part carries into the extra top bit of `mant_o`.
- R9: `ovf_inf_o` is 1 in nearest mode, 0 in toward-zero mode, 1 toward plus infinity only when `sign_i` is 0, and 1 toward minus infinity only when `sign_i` is 1.
- R10: `ovf_flag_o` is 1 exactly when `ovf_inf_o` selects infinity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 2 | Rounding direction: 00 nearest, 01 toward zero, 10 toward +inf, 11 toward -inf |
| sign_i | input | 1 | Operand sign, 1 = negative |
| mant_i | input | MANT_W | Aligned mantissa; bit 1 guard, bit 0 round |
| sticky_i | input | 1 | OR of every bit below the round bit |
| mant_o | output | MANT_W-1 | Rounded mantissa with guard/round removed, plus carry bit on top |
| round_up_o | output | 1 | An increment was applied |
| inexact_o | output | 1 | Discarded bits were nonzero |
| frac_inexact_o | output | 1 | Fraction-inexact flag, same condition as inexact |
| frac_rounded_o | output | 1 | Fraction was rounded up in magnitude |
| ovf_inf_o | output | 1 | On overflow deliver infinity (1) or largest finite value (0) |
| ovf_flag_o | output | 1 | Overflow flag raised because infinity is selected |

## Verification
The embedded checks assume the inputs are fully known and already settled. They also assume that `sticky_i` summarises the bits below the round bit, so any combination of guard, round and sticky is legal. The stimulus holds each vector stable for a whole clock period and compares only at the falling edge. It sweeps every mode and both signs over random mantissas. It also forces tie patterns with both even and odd kept LSBs, exact patterns, and an all-ones kept field that carries into the top bit.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

    typedef enum logic [1:0] {
        RM_NEAR   = 2'b00,
        RM_ZERO   = 2'b01,
        RM_POSINF = 2'b10,
        RM_NEGINF = 2'b11
    } rmode_e;

    typedef struct packed {
        logic guard;
        logic rnd;
        logic sticky;
    } lost_bits_t;

    function automatic logic any_lost(input lost_bits_t lb);
        return lb.guard | lb.rnd | lb.sticky;
    endfunction

endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
    import rnd_pkg::*;
(
    input  rmode_e     mode_i,
    input  logic       sign_i,
    input  lost_bits_t lost_i,
    input  logic       keep_lsb_i,
    output logic       inc_o,
    output logic       inexact_o
);
    logic lost_any;

    always_comb begin
        lost_any = any_lost(lost_i);
        inc_o    = 1'b0;
        if (lost_any) begin
            unique case (mode_i)
                RM_NEAR:   inc_o = lost_i.guard & (lost_i.rnd | lost_i.sticky | keep_lsb_i);
                RM_ZERO:   inc_o = 1'b0;
                RM_POSINF: inc_o = ~sign_i;
                RM_NEGINF: inc_o = sign_i;
                default:   inc_o = 1'b0;
            endcase
        end
        inexact_o = lost_any;
    end

    // R5: toward-zero mode never increments
    always_comb begin
        a_r5_zero_no_inc: assert (!(mode_i == RM_ZERO && inc_o));
    end

    // R4: nearest mode needs the guard bit to increment
    always_comb begin
        a_r4_near_needs_guard: assert (!(mode_i == RM_NEAR && inc_o && !lost_i.guard));
    end

endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
    parameter int KEEP_W = 24,
    localparam int OUT_W = KEEP_W + 1
) (
    input  logic [KEEP_W-1:0] keep_i,
    input  logic              inc_i,
    output logic [OUT_W-1:0]  sum_o
);
    always_comb begin
        sum_o = {1'b0, keep_i} + {{(OUT_W-1){1'b0}}, inc_i};
    end
endmodule

// File: rtl/rnd_ovf.sv
module rnd_ovf
    import rnd_pkg::*;
(
    input  rmode_e mode_i,
    input  logic   sign_i,
    output logic   to_inf_o,
    output logic   ovf_flag_o
);
    always_comb begin
        unique case (mode_i)
            RM_NEAR:   to_inf_o = 1'b1;
            RM_ZERO:   to_inf_o = 1'b0;
            RM_POSINF: to_inf_o = ~sign_i;
            RM_NEGINF: to_inf_o = sign_i;
            default:   to_inf_o = 1'b1;
        endcase
        ovf_flag_o = to_inf_o;
    end

    // R9: toward zero always clamps to the largest finite value
    always_comb begin
        a_r9_zero_clamps: assert (!(mode_i == RM_ZERO && to_inf_o));
    end
endmodule

// File: rtl/rnd_unit.sv
module rnd_unit
    import rnd_pkg::*;
#(
    parameter int MANT_W = 26,
    localparam int KEEP_W = MANT_W - 2,
    localparam int OUT_W  = KEEP_W + 1
) (
    input  logic [1:0]        mode_i,
    input  logic              sign_i,
    input  logic [MANT_W-1:0] mant_i,
    input  logic              sticky_i,
    output logic [OUT_W-1:0]  mant_o,
    output logic              round_up_o,
    output logic              inexact_o,
    output logic              frac_inexact_o,
    output logic              frac_rounded_o,
    output logic              ovf_inf_o,
    output logic              ovf_flag_o
);
    rmode_e            mode;
    lost_bits_t        lost;
    logic [KEEP_W-1:0] keep;
    logic              inc;
    logic              inx;

    always_comb begin
        mode        = rmode_e'(mode_i);
        lost.guard  = mant_i[1];
        lost.rnd    = mant_i[0];
        lost.sticky = sticky_i;
        keep        = mant_i[MANT_W-1:2];
    end

    rnd_decide u_decide (
        .mode_i     (mode),
        .sign_i     (sign_i),
        .lost_i     (lost),
        .keep_lsb_i (keep[0]),
        .inc_o      (inc),
        .inexact_o  (inx)
    );

    rnd_incr #(.KEEP_W(KEEP_W)) u_incr (
        .keep_i (keep),
        .inc_i  (inc),
        .sum_o  (mant_o)
    );

    rnd_ovf u_ovf (
        .mode_i     (mode),
        .sign_i     (sign_i),
        .to_inf_o   (ovf_inf_o),
        .ovf_flag_o (ovf_flag_o)
    );

    always_comb begin
        round_up_o     = inc;
        frac_rounded_o = inc;
        inexact_o      = inx;
        frac_inexact_o = inx;
    end

    // R2: an exact input raises nothing
    always_comb begin
        a_r2_exact_quiet: assert (!(!mant_i[1] && !mant_i[0] && !sticky_i && (round_up_o || inexact_o)));
    end

    // R3: an increment implies the result was inexact
    always_comb begin
        a_r3_inc_is_inexact: assert (!(round_up_o && !inexact_o));
    end

    // R1: without increment the adder passes the kept field and no carry
    always_comb begin
        a_r1_hold_value: assert (round_up_o || mant_o == {1'b0, mant_i[MANT_W-1:2]});
    end

    // R8: with increment the adder output is one above the kept field
    always_comb begin
        a_r8_carry_sum: assert (!round_up_o || mant_o == ({1'b0, mant_i[MANT_W-1:2]} + 1'b1));
    end

    // R10: overflow flag follows the infinity selection
    always_comb begin
        a_r10_flag_tracks_inf: assert (ovf_flag_o == ovf_inf_o);
    end

endmodule

// File: tb/rnd_unit_tb.sv
module rnd_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MANT_W = 26;
    localparam int KEEP_W = MANT_W - 2;
    localparam int OUT_W  = KEEP_W + 1;

    typedef struct {
        logic [OUT_W-1:0] mant;
        logic             inc;
        logic             inx;
        logic             inf;
        int               mode;
        logic             exact;
    } exp_t;

    logic              clk = 1'b0;
    logic [1:0]        mode_i = 2'b00;
    logic              sign_i = 1'b0;
    logic [MANT_W-1:0] mant_i = '0;
    logic              sticky_i = 1'b0;
    logic [OUT_W-1:0]  mant_o;
    logic              round_up_o, inexact_o, frac_inexact_o, frac_rounded_o;
    logic              ovf_inf_o, ovf_flag_o;

    int n_checks = 0;
    int n_fail   = 0;
    exp_t exp_q[$];
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rnd_unit #(.MANT_W(MANT_W)) u_dut (
        .mode_i, .sign_i, .mant_i, .sticky_i, .mant_o,
        .round_up_o, .inexact_o, .frac_inexact_o, .frac_rounded_o,
        .ovf_inf_o, .ovf_flag_o
    );

    task automatic chk(input string tag, input longint act, input longint expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // reference model in plain integer arithmetic
    task automatic drive(input int m, input bit s, input logic [MANT_W-1:0] v, input bit st);
        exp_t e;
        longint keep;
        bit g, r, lost, up;
        @(posedge clk);
        mode_i = m[1:0]; sign_i = s; mant_i = v; sticky_i = st;
        keep = longint'(v) / 4;
        g = v[1]; r = v[0];
        lost = g || r || st;
        up = 0;
        if (lost) begin
            if (m == 0) up = g && (r || st || (keep % 2 == 1));
            else if (m == 2) up = !s;
            else if (m == 3) up = s;
        end
        e.mant  = OUT_W'(keep + (up ? 1 : 0));
        e.inc   = up;
        e.inx   = lost;
        e.inf   = (m == 0) ? 1'b1 : (m == 1) ? 1'b0 : (m == 2) ? !s : s;
        e.mode  = m;
        e.exact = !lost;
        exp_q.push_back(e);
    endtask

    // monitor: compare at the falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            string rt;
            e = exp_q.pop_front();
            chk(e.inc ? "R8 mant" : "R1 mant", mant_o, e.mant);
            if (e.exact) rt = "R2 round_up";
            else case (e.mode)
                0: rt = "R4 round_up";
                1: rt = "R5 round_up";
                2: rt = "R6 round_up";
                default: rt = "R7 round_up";
            endcase
            chk(rt, round_up_o, e.inc);
            chk("R8 frac_rounded", frac_rounded_o, e.inc);
            chk("R3 inexact", inexact_o, e.inx);
            chk("R3 frac_inexact", frac_inexact_o, e.inx);
            chk("R9 ovf_inf", ovf_inf_o, e.inf);
            chk("R10 ovf_flag", ovf_flag_o, e.inf);
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, 100000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 2; s++) begin
                drive(m, s[0], 26'h0000A5C, 1'b0);         // exact
                drive(m, s[0], 26'h0000A52, 1'b0);         // tie, even kept LSB (R4)
                drive(m, s[0], 26'h0000A56, 1'b0);         // tie, odd kept LSB
                drive(m, s[0], 26'h0000A52, 1'b1);         // above tie via sticky
                drive(m, s[0], 26'h0000A53, 1'b0);         // above tie via round
                drive(m, s[0], 26'h0000A51, 1'b1);         // below half
                drive(m, s[0], {MANT_W{1'b1}}, 1'b0);      // carry into top bit
                drive(m, s[0], {{KEEP_W{1'b1}}, 2'b00}, 1'b1);
            end
        end
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            drive(int'(rv[31:30]), rv[29], MANT_W'($urandom), rv[28]);
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule